// File: doc/BRIEF.md
# Four-Stage In-Order 16-Bit Core

This block is a small in-order processor with a fetch, decode, execute and write-back pipeline. Instructions and data sit in two separate 256-word by 16-bit arrays inside the core. The testbench preloads the instruction array while reset is held. The core has four 16-bit general-purpose registers. Two operand registers, A and B, carry values from decode into execute. The core runs sixteen instructions: loads, stores, add and subtract (register or immediate forms), an unconditional jump and three conditional branches.

Hazards never cause a flush. If an instruction reads a register that the instruction in execute will write, decode holds for one cycle. The value then comes forward from write-back. A jump loads the PC in decode. A conditional branch freezes fetch and decode until it is resolved in write-back. Apart from clock and reset, the only ports are debug taps for the PC and the register file.

Top module: `qp_core`

## Requirements
- R1: While reset is active, the PC reads 0 and all four registers read 0. With an all-zero (NOP) instruction array, the PC rises by exactly one on each clock edge after reset is released.
- R2: An instruction word is laid out as opcode [15:12], destination [11:10], first source [9:8] and low byte [7:0]. The low byte holds either an immediate/address or, in its bits [1:0], the second source register. Opcode numbers are: NOP 0, load 1, load-immediate 2, store 3, ADD 4, ADDI 5, ADDS 6, ADDIS 7, SUB 8, SUBI 9, SUBS 10, SUBIS 11, JMP 12, BEQ 13, BGTU 14, BGTS 15.
- R3: Load-immediate writes the low byte, sign-extended to 16 bits, into the destination register.
- R4: The four add opcodes write (src1 + operand2) mod 2^16, where operand2 is either the second source register or the sign-extended immediate.
- R5: The four subtract opcodes write (src1 - operand2) mod 2^16, with operand2 formed as in R4.
- R6: A store writes the register named in [11:10] to data address [7:0]. A later load from that address returns the stored value, and the instruction that follows the load can use it.
- R7: JMP loads the PC with [7:0]. The instruction word that follows the jump is never executed.
- R8: BEQ, BGTU and BGTS compare the register in [11:10] with the register in [9:8] (equal, unsigned greater, signed greater). When the test is true, execution continues at [7:0]. Otherwise it continues at the next word.
- R9: An instruction that reads a register written by the instruction just before it sees the new value.
- R10: NOP, store, JMP and the branches write no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| dbg_pc | output | 8 | Current fetch address |
| dbg_regs | output | 64 | Register file; register i is bits [16i+15:16i] |

## Verification
Two things can happen in the same cycle: write-back writing a register, and decode reading that same register through the forwarding path. Every sweep program provokes this. It loads an operand with load-immediate and then uses it in the very next instruction, an ALU operation or a branch. The bench first computes the expected sums, differences and branch outcomes from the sign-extended inputs. It then judges the results by comparing them with the final register values. A stale register value shows up as a wrong result or a wrong branch path.

// File: rtl/qp_pkg.sv
package qp_pkg;
    localparam int DW        = 16;
    localparam int AW        = 8;
    localparam int RN        = 4;
    localparam int RW        = $clog2(RN);
    localparam int ROM_DEPTH = 1 << AW;
    localparam int RAM_DEPTH = 1 << AW;

    typedef enum logic [3:0] {
        OP_NOP   = 4'd0,  OP_LDM  = 4'd1,  OP_LDI   = 4'd2,  OP_STM  = 4'd3,
        OP_ADD   = 4'd4,  OP_ADDI = 4'd5,  OP_ADDS  = 4'd6,  OP_ADDSI = 4'd7,
        OP_SUB   = 4'd8,  OP_SUBI = 4'd9,  OP_SUBS  = 4'd10, OP_SUBSI = 4'd11,
        OP_JMP   = 4'd12, OP_BEQ  = 4'd13, OP_BGTU  = 4'd14, OP_BGTS  = 4'd15
    } op_e;

    typedef struct packed {
        op_e           op;
        logic          use_a;
        logic [RW-1:0] sel_a;
        logic          use_b;
        logic [RW-1:0] sel_b;
        logic          b_imm;
        logic          wr;
        logic [RW-1:0] dest;
        logic [AW-1:0] imm;
    } dec_t;

    typedef struct packed {
        op_e           op;
        logic          wr;
        logic [RW-1:0] dest;
        logic [DW-1:0] a;
        logic [DW-1:0] b;
        logic [AW-1:0] imm;
    } exq_t;

    typedef struct packed {
        op_e           op;
        logic          wr;
        logic [RW-1:0] dest;
        logic [DW-1:0] res;
        logic          eq;
        logic          gtu;
        logic          gts;
        logic [AW-1:0] imm;
    } wbq_t;

    function automatic logic [DW-1:0] sext(input logic [AW-1:0] v);
        return {{(DW-AW){v[AW-1]}}, v};
    endfunction

    function automatic logic is_branch(input op_e o);
        return (o == OP_BEQ) || (o == OP_BGTU) || (o == OP_BGTS);
    endfunction
endpackage

// File: rtl/qp_decode.sv
module qp_decode
    import qp_pkg::*;
(
    input  logic [DW-1:0] ir,
    output dec_t          d
);
    always_comb begin
        d       = '0;
        d.op    = op_e'(ir[15:12]);
        d.dest  = ir[11:10];
        d.imm   = ir[AW-1:0];
        d.sel_a = ir[9:8];
        d.sel_b = ir[RW-1:0];
        case (d.op)
            OP_LDM, OP_LDI: begin
                d.b_imm = 1'b1;
                d.wr    = 1'b1;
            end
            OP_STM: begin
                d.use_a = 1'b1;
                d.sel_a = ir[11:10];
                d.b_imm = 1'b1;
            end
            OP_ADD, OP_ADDS, OP_SUB, OP_SUBS: begin
                d.use_a = 1'b1;
                d.use_b = 1'b1;
                d.wr    = 1'b1;
            end
            OP_ADDI, OP_ADDSI, OP_SUBI, OP_SUBSI: begin
                d.use_a = 1'b1;
                d.b_imm = 1'b1;
                d.wr    = 1'b1;
            end
            OP_BEQ, OP_BGTU, OP_BGTS: begin
                d.use_a = 1'b1;
                d.use_b = 1'b1;
                d.sel_a = ir[11:10];
                d.sel_b = ir[9:8];
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/qp_exec.sv
module qp_exec
    import qp_pkg::*;
(
    input  exq_t          x,
    input  logic [DW-1:0] mem_rd,
    output wbq_t          y
);
    always_comb begin
        y      = '0;
        y.op   = x.op;
        y.wr   = x.wr;
        y.dest = x.dest;
        y.imm  = x.imm;
        y.eq   = (x.a == x.b);
        y.gtu  = (x.a > x.b);
        y.gts  = ($signed(x.a) > $signed(x.b));
        case (x.op)
            OP_LDM:                               y.res = mem_rd;
            OP_LDI:                               y.res = x.b;
            OP_ADD, OP_ADDI, OP_ADDS, OP_ADDSI:   y.res = x.a + x.b;
            OP_SUB, OP_SUBI, OP_SUBS, OP_SUBSI:   y.res = x.a - x.b;
            default:                              y.res = '0;
        endcase
    end
endmodule

// File: rtl/qp_regfile.sv
module qp_regfile
    import qp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [RW-1:0]    wa,
    input  logic [DW-1:0]    wd,
    input  logic [RW-1:0]    ra0,
    input  logic [RW-1:0]    ra1,
    output logic [DW-1:0]    rd0,
    output logic [DW-1:0]    rd1,
    output logic [RN*DW-1:0] dump
);
    logic [DW-1:0] rf [RN];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < RN; i++) rf[i] <= '0;
        end else if (we) begin
            rf[wa] <= wd;
        end
    end

    // write-back value bypasses the array when decode reads the same entry
    assign rd0 = (we && wa == ra0) ? wd : rf[ra0];
    assign rd1 = (we && wa == ra1) ? wd : rf[ra1];

    for (genvar g = 0; g < RN; g++) begin : g_dump
        assign dump[g*DW +: DW] = rf[g];
    end
endmodule

// File: rtl/qp_core.sv
module qp_core
    import qp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    output logic [AW-1:0]    dbg_pc,
    output logic [RN*DW-1:0] dbg_regs
);
    logic [DW-1:0] imem [ROM_DEPTH];
    logic [DW-1:0] dmem [RAM_DEPTH];

    initial begin
        for (int i = 0; i < ROM_DEPTH; i++) imem[i] = '0;
    end

    logic [AW-1:0] pc;
    logic [DW-1:0] ir;
    dec_t          dec;
    exq_t          exq, ex_in;
    wbq_t          wbq, wb_next;
    logic [DW-1:0] rd0, rd1, mem_rd;
    logic          busy, taken, hazard, hz_stall, issue;

    qp_decode u_dec (.ir(ir), .d(dec));

    qp_regfile u_rf (
        .clk(clk), .rst(rst),
        .we(wbq.wr), .wa(wbq.dest), .wd(wbq.res),
        .ra0(dec.sel_a), .ra1(dec.sel_b),
        .rd0(rd0), .rd1(rd1), .dump(dbg_regs)
    );

    assign mem_rd = dmem[exq.b[AW-1:0]];

    qp_exec u_ex (.x(exq), .mem_rd(mem_rd), .y(wb_next));

    assign busy   = is_branch(exq.op) || is_branch(wbq.op);
    assign taken  = (wbq.op == OP_BEQ  && wbq.eq)
                 || (wbq.op == OP_BGTU && wbq.gtu)
                 || (wbq.op == OP_BGTS && wbq.gts);
    assign hazard = exq.wr && ((dec.use_a && dec.sel_a == exq.dest)
                            || (dec.use_b && dec.sel_b == exq.dest));
    assign hz_stall = hazard && !busy;
    assign issue    = !busy && !hazard;

    always_comb begin
        ex_in    = '0;
        ex_in.op = OP_NOP;
        if (issue) begin
            ex_in.op   = dec.op;
            ex_in.wr   = dec.wr;
            ex_in.dest = dec.dest;
            ex_in.a    = rd0;
            ex_in.b    = dec.b_imm ? sext(dec.imm) : rd1;
            ex_in.imm  = dec.imm;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc  <= '0;
            ir  <= '0;
            exq <= '0;
            wbq <= '0;
        end else begin
            exq <= ex_in;
            wbq <= wb_next;
            if (taken) begin
                pc <= wbq.imm;
            end else if (busy || hazard) begin
                pc <= pc;
            end else if (dec.op == OP_JMP) begin
                pc <= dec.imm;
                ir <= '0;
            end else if (is_branch(dec.op)) begin
                ir <= '0;
            end else begin
                ir <= imem[pc];
                pc <= pc + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst && exq.op == OP_STM) dmem[exq.b[AW-1:0]] <= exq.a;
    end

    assign dbg_pc = pc;
endmodule

// File: rtl/qp_core_chk.sv
module qp_core_chk
    import qp_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [AW-1:0]    pc,
    input logic [DW-1:0]    ir,
    input logic [RN*DW-1:0] regs,
    input op_e              ex_op,
    input logic             wb_wr,
    input logic             hz_stall
);
    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (pc == '0 && regs == '0));

    p_jump_load_r7: assert property (@(posedge clk) disable iff (rst)
        (ir[15:12] == OP_JMP) |=> (pc == $past(ir[AW-1:0])));

    p_branch_hold_r8: assert property (@(posedge clk) disable iff (rst)
        is_branch(ex_op) |=> $stable(pc));

    p_hazard_hold_r9: assert property (@(posedge clk) disable iff (rst)
        hz_stall |=> ($stable(ir) && $stable(pc)));

    p_quiet_regs_r10: assert property (@(posedge clk) disable iff (rst)
        !wb_wr |=> $stable(regs));
endmodule

bind qp_core qp_core_chk u_chk (
    .clk(clk), .rst(rst), .pc(pc), .ir(ir), .regs(dbg_regs),
    .ex_op(exq.op), .wb_wr(wbq.wr), .hz_stall(hz_stall)
);

// File: tb/qp_core_tb.sv
module qp_core_tb;
    import qp_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [AW-1:0]    dbg_pc;
    logic [RN*DW-1:0] dbg_regs;

    always #4 clk = ~clk;

    qp_core u_dut (.clk(clk), .rst(rst), .dbg_pc(dbg_pc), .dbg_regs(dbg_regs));

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] rget(input int i);
        return dbg_regs[16*i +: 16];
    endfunction

    function automatic logic [15:0] enc(input int op, input int d, input int s, input logic [7:0] lo);
        return {op[3:0], d[1:0], s[1:0], lo};
    endfunction

    function automatic logic [15:0] sx(input logic [7:0] v);
        return {{8{v[7]}}, v};
    endfunction

    task automatic clear_rom();
        for (int i = 0; i < ROM_DEPTH; i++) u_dut.imem[i] = 16'h0000;
    endtask

    task automatic hold_reset();
        rst = 1'b1;
        clear_rom();
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic run(input int n);
        rst = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    logic [7:0] vals [8] = '{8'h00, 8'h01, 8'h02, 8'h7F, 8'h80, 8'hFF, 8'h55, 8'hAA};

    initial begin
        logic [15:0] sa, sb, exp16;
        bit          tk;

        // R1: reset state and free-running PC over NOPs
        hold_reset();
        chk("R1 reset pc", 32'(dbg_pc), 32'h0);
        chk("R1 reset regs", dbg_regs[31:0], 32'h0);
        run(5);
        chk("R1 pc advance", 32'(dbg_pc), 32'h5);

        // ALU sweep: R2 R3 R4 R5 R9 R10
        for (int op = 4; op <= 11; op++) begin
            for (int i = 0; i < 8; i++) begin
                for (int j = 0; j < 8; j++) begin
                    hold_reset();
                    u_dut.imem[0] = enc(2, 1, 0, vals[i]);
                    u_dut.imem[1] = enc(2, 2, 0, vals[j]);
                    u_dut.imem[2] = (op % 2 == 1) ? enc(op, 3, 1, vals[j]) : enc(op, 3, 1, 8'd2);
                    u_dut.imem[3] = enc(12, 0, 0, 8'd3);
                    run(40);
                    sa = sx(vals[i]);
                    sb = sx(vals[j]);
                    exp16 = (op >= 8) ? 16'(sa - sb) : 16'(sa + sb);
                    chk($sformatf("%s R9 op=%0d a=%h b=%h", (op >= 8) ? "R5" : "R4", op, vals[i], vals[j]),
                        32'(rget(3)), 32'(exp16));
                    chk($sformatf("R2 R3 r1 a=%h", vals[i]), 32'(rget(1)), 32'(sa));
                    chk("R10 r0 untouched", 32'(rget(0)), 32'h0);
                end
            end
        end

        // Branch sweep: R8 R9 R10
        for (int op = 13; op <= 15; op++) begin
            for (int i = 0; i < 8; i++) begin
                for (int j = 0; j < 8; j++) begin
                    hold_reset();
                    u_dut.imem[0] = enc(2, 0, 0, vals[i]);
                    u_dut.imem[1] = enc(2, 1, 0, vals[j]);
                    u_dut.imem[2] = enc(op, 0, 1, 8'd5);
                    u_dut.imem[3] = enc(2, 2, 0, 8'd1);
                    u_dut.imem[4] = enc(12, 0, 0, 8'd6);
                    u_dut.imem[5] = enc(2, 2, 0, 8'd2);
                    u_dut.imem[6] = enc(2, 3, 0, 8'h33);
                    u_dut.imem[7] = enc(12, 0, 0, 8'd7);
                    run(40);
                    sa = sx(vals[i]);
                    sb = sx(vals[j]);
                    if (op == 13)      tk = (sa == sb);
                    else if (op == 14) tk = (sa > sb);
                    else               tk = ($signed(sa) > $signed(sb));
                    chk($sformatf("R8 R9 op=%0d a=%h b=%h path", op, vals[i], vals[j]),
                        32'(rget(2)), tk ? 32'h2 : 32'h1);
                    chk("R8 join", 32'(rget(3)), 32'h33);
                    chk("R10 branch no write", 32'(rget(0)), 32'(sa));
                end
            end
        end

        // R7: jump skips the next word
        hold_reset();
        u_dut.imem[0] = enc(12, 0, 0, 8'd2);
        u_dut.imem[1] = enc(2, 0, 0, 8'h11);
        u_dut.imem[2] = enc(2, 1, 0, 8'h22);
        u_dut.imem[3] = enc(12, 0, 0, 8'd3);
        run(30);
        chk("R7 skipped word", 32'(rget(0)), 32'h0);
        chk("R7 target executed", 32'(rget(1)), 32'h22);
        chk("R10 jump no write", 32'(rget(2)), 32'h0);

        // R6: store/load round trip with dependent use
        hold_reset();
        u_dut.imem[0] = enc(2, 0, 0, 8'h5A);
        u_dut.imem[1] = enc(2, 1, 0, 8'hFD);
        u_dut.imem[2] = enc(3, 1, 0, 8'h20);
        u_dut.imem[3] = enc(3, 0, 0, 8'h10);
        u_dut.imem[4] = enc(1, 2, 0, 8'h10);
        u_dut.imem[5] = enc(1, 3, 0, 8'h20);
        u_dut.imem[6] = enc(4, 0, 2, 8'd3);
        u_dut.imem[7] = enc(12, 0, 0, 8'd7);
        run(40);
        chk("R6 load a", 32'(rget(2)), 32'h005A);
        chk("R6 load b", 32'(rget(3)), 32'hFFFD);
        chk("R6 R9 load-use add", 32'(rget(0)), 32'h0057);
        chk("R10 store no write", 32'(rget(1)), 32'hFFFD);

        // R1: reset clears a populated register file
        hold_reset();
        chk("R1 re-reset pc", 32'(dbg_pc), 32'h0);
        chk("R1 re-reset regs hi", dbg_regs[63:32], 32'h0);
        chk("R1 re-reset regs lo", dbg_regs[31:0], 32'h0);
        run(3);
        chk("R1 R10 nop pc", 32'(dbg_pc), 32'h3);
        chk("R10 nop regs", dbg_regs[31:0], 32'h0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule